// File: doc/BRIEF.md
# Fractional M/N Audio Clock Generator

This block derives an audio bit clock whose rate is a rational fraction M/N of a chosen parent rate. It runs on one system clock. Each of three parent sources is presented as a one-cycle tick on the system clock. A phase accumulator advances on every tick of the selected source. Each time the accumulated phase crosses the divisor, the output clock toggles, so the result is a square wave at parent × M / N.

One 32-bit configuration word holds the whole setting: a 2-bit source selector in bits [31:30], an enable in bit 29, a 9-bit multiplier M in bits [28:20] and a 20-bit divisor N in bits [19:0]. Software writes the word in one cycle and may read it back. A valid setting needs M ≥ 1 and 2·M ≤ N. Any other setting, or a cleared enable, forces the output low.

Top module: `mnclk_audio_gen`

## Requirements
- R1: `cfg_rdata` returns the last 32-bit word written through `cfg_wr`/`cfg_wdata`, unchanged, from the cycle after the write.
- R2: After reset `clk_out` is 0 and `cfg_rdata` is 0.
- R3: On each selected tick with a valid, enabled setting, 2·M is added to the phase. If the sum is at least N, N is subtracted and `clk_out` toggles, with the new level visible in the cycle after the tick. With no tick the output holds.
- R4: Starting from a cleared phase and a low output, exactly M rising edges of `clk_out` occur over N selected ticks.
- R5: Bits [31:30] choose the source tick: 00 selects `src_tick[0]`, 01 selects `src_tick[1]`, and 10 or 11 select `src_tick[2]`. Ticks on the other sources neither move the phase nor the output.
- R6: While bit 29 is 0, `clk_out` is 0 from the cycle after that setting is loaded and the phase is held at zero. After re-enabling, the first toggle comes after ceil(N/(2·M)) ticks.
- R7: If M is 0, N is 0, or 2·M > N, `clk_out` is held at 0 whatever ticks arrive.
- R8: Any configuration write clears the phase and leaves the output level unchanged. A tick in the write cycle is discarded, and the new M and N apply from the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: source[31:30], enable[29], M[28:20], N[19:0] |
| cfg_rdata | output | 32 | Current configuration word |
| src_tick | input | 3 | One-cycle tick per parent source |
| clk_out | output | 1 | Generated audio clock |

## Verification
The hardest state to observe from the ports is the hidden phase value. Ignored ticks, discarded write-cycle ticks and a cleared phase all leave `clk_out` unchanged at first. The stimulus therefore sets up M=1, N=4, where the first toggle lands exactly on the second counted tick. It then applies the disturbing event and counts ticks to the next toggle. A phase that was wrongly advanced or not cleared shows up as a toggle one tick early. The rate itself is checked by counting rising edges over exactly N ticks from a fresh enable, including the fastest ratio, where every tick toggles.

// File: rtl/mnclk_pkg.sv
package mnclk_pkg;

    localparam int MUL_W  = 9;
    localparam int DIV_W  = 20;
    localparam int SRC_W  = 2;
    localparam int NUM_SRC = 3;
    localparam int CFG_W  = SRC_W + 1 + MUL_W + DIV_W;
    localparam int SUM_W  = DIV_W + 1;

    typedef enum logic [SRC_W-1:0] {
        SRC_A  = 2'b00,
        SRC_B  = 2'b01,
        SRC_C  = 2'b10,
        SRC_C2 = 2'b11
    } src_sel_e;

    // Packed order matches the configuration word layout.
    typedef struct packed {
        src_sel_e           src;
        logic               en;
        logic [MUL_W-1:0]   mul;
        logic [DIV_W-1:0]   div;
    } mn_cfg_t;

    // Legal ratio: nonzero multiplier, half-period step not above divisor.
    function automatic logic ratio_ok(mn_cfg_t c);
        logic [SUM_W-1:0] step;
        step = SUM_W'({c.mul, 1'b0});
        return (c.mul != '0) && (c.div != '0) && (step <= SUM_W'(c.div));
    endfunction

    function automatic int src_index(src_sel_e s);
        return s[1] ? 2 : (s[0] ? 1 : 0);
    endfunction

endpackage

// File: rtl/mnclk_cfg_reg.sv
module mnclk_cfg_reg
    import mnclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CFG_W-1:0]  wdata,
    output mn_cfg_t           cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= mn_cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/mnclk_src_sel.sv
module mnclk_src_sel
    import mnclk_pkg::*;
(
    input  src_sel_e              src,
    input  logic [NUM_SRC-1:0]    src_tick,
    output logic                  tick
);

    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            assign hit[g] = src_tick[g] && (src_index(src) == g);
        end
    endgenerate

    assign tick = |hit;

endmodule

// File: rtl/mnclk_phase_acc.sv
module mnclk_phase_acc
    import mnclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mn_cfg_t  cfg,
    input  logic     wr,
    input  logic     tick,
    output logic     clk_out
);

    logic [DIV_W-1:0] acc;
    logic [SUM_W-1:0] sum;
    logic             run;
    logic             wrap;

    assign run  = cfg.en && ratio_ok(cfg);
    assign sum  = SUM_W'(acc) + SUM_W'({cfg.mul, 1'b0});
    assign wrap = (sum >= SUM_W'(cfg.div));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc     <= '0;
            clk_out <= 1'b0;
        end else if (wr) begin
            acc     <= '0;
        end else if (tick) begin
            if (wrap) begin
                acc     <= DIV_W'(sum - SUM_W'(cfg.div));
                clk_out <= ~clk_out;
            end else begin
                acc     <= DIV_W'(sum);
            end
        end
    end

    // R3: phase stays below the divisor whenever the setting is legal
    a_r3_acc_below_div: assert property (@(posedge clk) disable iff (rst)
        run |-> (acc < cfg.div))
        else $error("a_r3_acc_below_div");

    // R8: a write leaves the phase at zero
    a_r8_wr_clears: assert property (@(posedge clk) disable iff (rst)
        wr |=> (acc == '0))
        else $error("a_r8_wr_clears");

    // R3: without a tick the output does not move
    a_r3_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(clk_out))
        else $error("a_r3_idle_stable");

endmodule

// File: rtl/mnclk_audio_gen.sv
module mnclk_audio_gen
    import mnclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [31:0]         cfg_wdata,
    output logic [31:0]         cfg_rdata,
    input  logic [2:0]          src_tick,
    output logic                clk_out
);

    mn_cfg_t cfg_q;
    logic    sel_tick;

    mnclk_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    mnclk_src_sel u_sel (
        .src      (cfg_q.src),
        .src_tick (src_tick),
        .tick     (sel_tick)
    );

    mnclk_phase_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .wr      (cfg_wr),
        .tick    (sel_tick),
        .clk_out (clk_out)
    );

    assign cfg_rdata = cfg_q;

    // R6: disabled setting forces the output low
    a_r6_off_low: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |=> !clk_out)
        else $error("a_r6_off_low");

    // R7: illegal ratio forces the output low
    a_r7_bad_ratio_low: assert property (@(posedge clk) disable iff (rst)
        !ratio_ok(cfg_q) |=> !clk_out)
        else $error("a_r7_bad_ratio_low");

endmodule

// File: tb/test_mnclk_audio_gen.sv
`timescale 1ns/1ps
module test_mnclk_audio_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [2:0]  src_tick;
    logic        clk_out;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    mnclk_audio_gen i_mnclk_audio_gen (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .src_tick  (src_tick),
        .clk_out   (clk_out)
    );

    function automatic logic [31:0] word(input logic [1:0] s, input logic e,
                                         input int m, input int n);
        return {s, e, m[8:0], n[19:0]};
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_tick = 3'b0; src_tick[idx] = 1'b1;
        @(negedge clk);
        src_tick = 3'b0;
    endtask

    task automatic start(input logic [1:0] s, input int m, input int n);
        write_cfg(word(s, 1'b0, m, n));
        @(negedge clk);
        write_cfg(word(s, 1'b1, m, n));
    endtask

    task automatic t_reset;
        check("R2 clk_out after reset", clk_out, 0);
        check("R2 cfg_rdata after reset", cfg_rdata, 0);
    endtask

    task automatic t_readback;
        write_cfg(32'hA5A5_5A5A);
        check("R1 readback pattern", cfg_rdata, 32'hA5A5_5A5A);
        write_cfg(word(2'b01, 1'b1, 3, 10));
        check("R1 readback fields", cfg_rdata, 32'h6030_000A);
    endtask

    task automatic t_toggle;
        start(2'b00, 1, 4);
        check("R3 after enable", clk_out, 0);
        pulse(0); check("R3 tick1", clk_out, 0);
        pulse(0); check("R3 tick2", clk_out, 1);
        repeat (3) @(negedge clk);
        check("R3 idle hold", clk_out, 1);
        pulse(0); check("R3 tick3", clk_out, 1);
        pulse(0); check("R3 tick4", clk_out, 0);
    endtask

    task automatic ratio(input int m, input int n);
        int edges = 0;
        logic prev;
        start(2'b00, m, n);
        prev = clk_out;
        for (int i = 0; i < n; i++) begin
            pulse(0);
            if (clk_out && !prev) edges++;
            prev = clk_out;
        end
        check($sformatf("R4 edges M=%0d N=%0d", m, n), edges, m);
    endtask

    task automatic t_ratio;
        ratio(3, 10);
        ratio(5, 16);
        ratio(511, 1022);
        ratio(7, 20000);
    endtask

    task automatic t_source;
        start(2'b01, 1, 4);
        for (int i = 0; i < 3; i++) begin pulse(0); pulse(2); end
        check("R5 sel01 ignores A and C", clk_out, 0);
        pulse(1); check("R5 sel01 B tick1", clk_out, 0);
        pulse(1); check("R5 sel01 B tick2", clk_out, 1);
        start(2'b10, 1, 4);
        pulse(0); pulse(1);
        pulse(2); check("R5 sel10 C tick1", clk_out, 0);
        pulse(2); check("R5 sel10 C tick2", clk_out, 1);
        start(2'b11, 1, 4);
        pulse(1); pulse(2);
        check("R5 sel11 C tick1", clk_out, 0);
        pulse(2); check("R5 sel11 C tick2", clk_out, 1);
    endtask

    task automatic t_enable;
        start(2'b00, 1, 4);
        pulse(0); pulse(0);
        check("R6 running high", clk_out, 1);
        write_cfg(word(2'b00, 1'b0, 1, 4));
        @(negedge clk);
        check("R6 disabled low", clk_out, 0);
        for (int i = 0; i < 5; i++) pulse(0);
        check("R6 ticks while disabled", clk_out, 0);
        write_cfg(word(2'b00, 1'b1, 1, 4));
        pulse(0); check("R6 reenable tick1", clk_out, 0);
        pulse(0); check("R6 reenable tick2", clk_out, 1);
    endtask

    task automatic t_invalid;
        start(2'b00, 0, 8);
        for (int i = 0; i < 20; i++) pulse(0);
        check("R7 M zero", clk_out, 0);
        start(2'b00, 3, 0);
        for (int i = 0; i < 20; i++) pulse(0);
        check("R7 N zero", clk_out, 0);
        start(2'b00, 3, 5);
        for (int i = 0; i < 20; i++) pulse(0);
        check("R7 2M above N", clk_out, 0);
    endtask

    task automatic t_wr_clear;
        start(2'b00, 1, 4);
        pulse(0);
        write_cfg(word(2'b00, 1'b1, 1, 4));
        pulse(0); check("R8 phase cleared tick1", clk_out, 0);
        pulse(0); check("R8 phase cleared tick2", clk_out, 1);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = word(2'b00, 1'b1, 1, 4); src_tick = 3'b001;
        @(negedge clk);
        cfg_wr = 1'b0; src_tick = 3'b0;
        check("R8 level kept on write", clk_out, 1);
        pulse(0); check("R8 write-cycle tick dropped", clk_out, 1);
        pulse(0); check("R8 toggle after two", clk_out, 0);
        write_cfg(word(2'b00, 1'b1, 2, 4));
        pulse(0); check("R8 new M applies", clk_out, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0; src_tick = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_readback;
        t_toggle;
        t_ratio;
        t_source;
        t_enable;
        t_invalid;
        t_wr_clear;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule